// File: doc/BRIEF.md
# I2C Control Register and Command Sequencer

This block is the software-visible control register of a combined master/slave I2C peripheral, together with the small amount of logic that turns its bits into requests for a byte-level bus engine. The CPU writes and reads one 8-bit register. The engine reports what happened on the bus through single-cycle event pulses and a few level inputs. The block answers with start, stop, acknowledge, general-call acknowledge, line-release and clock-hold requests, and with one interrupt line.

Turning the interface on takes two writes: the first write only raises the enable bit, and the second write loads the other bits. Each control bit is also cleared by hardware under its own rule. The start and stop bits are read differently depending on whether the engine is acting as master or as slave. Event flags are held inside the block until software clears them through a per-flag clear pulse. They feed both the interrupt and the clock-hold output.

Top module: `i2c_ctl_seq`

## Requirements
- R1: After reset the register reads 00h. Bits 7:6 always read 0. The layout is bit 5 enable, bit 4 general-call enable, bit 3 start, bit 2 acknowledge enable, bit 1 stop, bit 0 interrupt enable.
- R2: A write made while enable is 0 changes only the enable bit. The stop bit keeps its value and every other bit stays 0. A write made while enable is 1 loads all six bits. When that write clears enable, bits 4, 3, 2 and 0 are loaded as 0.
- R3: While enable is 0, bits 4, 3, 2 and 0 read 0. Flags 0 to 3 are cleared and the stop flag is kept. Start request, stop request, acknowledge, line release and clock hold are all 0.
- R4: gc_ack is 1 in the cycle after a received address byte of 00h, provided enable and general-call enable were both 1. It is never set for any other address byte, 01h included.
- R5: A start-sent event while enabled clears the start bit and sets flag 0. A software write in the same cycle takes priority over the hardware clear.
- R6: req_start is enable AND start AND (is_master OR bus_free). In slave mode a start is therefore requested only while the bus is free.
- R7: ack_out equals enable AND the acknowledge-enable bit.
- R8: In master mode, req_stop is 1 when stop=1, start=0, and a start-sent or byte-done event has occurred since the last stop-sent event or disable. When start and stop are both set, the start request comes first and the stop request follows. A stop-sent event in master mode clears the stop bit.
- R9: In slave mode with stop=1, a byte-done event raises release_lines from the next cycle. release_lines stays 1 until stop is cleared, enable drops or master mode is entered. Hardware never clears stop in slave mode.
- R10: scl_hold is enable AND (any of flags 0 to 3 OR hold_pend). Flag 0 is start sent, flag 1 is 10-bit header sent, flag 2 is byte done and flag 3 is address matched.
- R11: irq is the interrupt-enable bit AND any of the five flags, where flag 4 is stop sent. Each event sets its flag. flag_clr[i] clears flag i, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Live register value |
| is_master | input | 1 | Engine is acting as bus master |
| bus_free | input | 1 | No transfer in progress on the bus |
| ev_start_sent | input | 1 | Start condition sent (pulse) |
| ev_stop_sent | input | 1 | Stop condition sent (pulse) |
| ev_byte_done | input | 1 | Byte transfer finished (pulse) |
| ev_addr_match | input | 1 | Own address matched (pulse) |
| ev_hdr10 | input | 1 | 10-bit header sent (pulse) |
| addr_valid | input | 1 | Received address byte valid (pulse) |
| addr_byte | input | 8 | Received address byte |
| hold_pend | input | 1 | Address-matched-and-status-read event outstanding |
| flag_clr | input | 5 | Per-flag clear pulses, bit i clears flag i |
| req_start | output | 1 | Request a start condition |
| req_stop | output | 1 | Request a stop condition |
| ack_out | output | 1 | Acknowledge received bytes |
| gc_ack | output | 1 | Acknowledge the general-call address |
| release_lines | output | 1 | Slave releases SCL and SDA |
| scl_hold | output | 1 | Hold SCL low |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences exercise the two-write enable, a combined start-and-stop request in master mode where the start must come out first, a slave start that waits for a free bus, and a slave stop that must survive a stop-sent event. The general call is tried with 00h and 01h to separate a full-byte compare from a low-bit-only compare. A long random phase then mixes writes, events, clears and mode changes on a fixed seed against a cycle model. This exposes wrong priorities between writes and hardware clears, and between flag sets and flag clears.

// File: rtl/i2c_ctl_seq.sv
module i2c_ctl_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       is_master,
  input  logic       bus_free,
  input  logic       ev_start_sent,
  input  logic       ev_stop_sent,
  input  logic       ev_byte_done,
  input  logic       ev_addr_match,
  input  logic       ev_hdr10,
  input  logic       addr_valid,
  input  logic [7:0] addr_byte,
  input  logic       hold_pend,
  input  logic [4:0] flag_clr,
  output logic       req_start,
  output logic       req_stop,
  output logic       ack_out,
  output logic       gc_ack,
  output logic       release_lines,
  output logic       scl_hold,
  output logic       irq
);

  logic       en_q, gce_q, sta_q, ack_q, sto_q, ie_q;
  logic [4:0] flg_q;
  logic       arm_q, rel_q, gc_q;
  logic [4:0] flg_set;

  assign flg_set = {ev_stop_sent, ev_addr_match, ev_byte_done, ev_hdr10, ev_start_sent};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0; gce_q <= 1'b0; sta_q <= 1'b0;
      ack_q <= 1'b0; sto_q <= 1'b0; ie_q <= 1'b0;
    end else if (wr_en) begin
      en_q <= wr_data[5];
      if (en_q) begin
        gce_q <= wr_data[5] & wr_data[4];
        sta_q <= wr_data[5] & wr_data[3];
        ack_q <= wr_data[5] & wr_data[2];
        sto_q <= wr_data[1];
        ie_q  <= wr_data[5] & wr_data[0];
      end
    end else begin
      if (en_q && ev_start_sent) sta_q <= 1'b0;
      if (en_q && is_master && ev_stop_sent) sto_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flg_q <= '0;
    else begin
      flg_q[4] <= (flg_q[4] & ~flag_clr[4]) | flg_set[4];
      if (!en_q) flg_q[3:0] <= '0;
      else       flg_q[3:0] <= (flg_q[3:0] & ~flag_clr[3:0]) | flg_set[3:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en_q || ev_stop_sent) arm_q <= 1'b0;
    else if (ev_start_sent || ev_byte_done) arm_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !en_q || !sto_q || is_master) rel_q <= 1'b0;
    else if (ev_byte_done) rel_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) gc_q <= 1'b0;
    else     gc_q <= en_q & gce_q & addr_valid & (addr_byte == 8'h00);
  end

  assign rd_data       = {2'b00, en_q, gce_q, sta_q, ack_q, sto_q, ie_q};
  assign req_start     = en_q & sta_q & (is_master | bus_free);
  assign req_stop      = en_q & is_master & sto_q & ~sta_q & arm_q;
  assign ack_out       = en_q & ack_q;
  assign gc_ack        = gc_q;
  assign release_lines = en_q & rel_q;
  assign scl_hold      = en_q & ((|flg_q[3:0]) | hold_pend);
  assign irq           = ie_q & (|flg_q);

  assert_dis_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!rd_data[5] && wr_en) |=> (rd_data[4:2] == 3'b000 && !rd_data[0]));

  assert_released_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_data[5] |-> !(req_start || req_stop || ack_out || scl_hold || release_lines));

  assert_gc_match_R4: assert property (@(posedge clk) disable iff (rst)
    gc_ack |-> ($past(addr_valid) && $past(addr_byte) == 8'h00));

  assert_start_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_data[5] && ev_start_sent && !wr_en) |=> !rd_data[3]);

  assert_order_R8: assert property (@(posedge clk) disable iff (rst)
    req_stop |-> !req_start);

  assert_slave_stop_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_data[5] && !is_master && rd_data[1] && !wr_en) |=> rd_data[1]);

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> rd_data[0]);

endmodule

// File: tb/i2c_ctl_seq_bench.sv
module i2c_ctl_seq_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, is_master = 0, bus_free = 0;
  logic ev_start_sent = 0, ev_stop_sent = 0, ev_byte_done = 0, ev_addr_match = 0, ev_hdr10 = 0;
  logic addr_valid = 0, hold_pend = 0;
  logic [7:0] wr_data = 0, addr_byte = 0;
  logic [4:0] flag_clr = 0;
  logic [7:0] rd_data;
  logic req_start, req_stop, ack_out, gc_ack, release_lines, scl_hold, irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench-side model state
  logic m_en, m_gce, m_sta, m_ack, m_sto, m_ie, m_arm, m_rel, m_gc;
  logic [4:0] m_flg;

  i2c_ctl_seq u_i2c_ctl_seq (.*);

  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_reg();
    return {2'b00, m_en, m_gce, m_sta, m_ack, m_sto, m_ie};
  endfunction

  task automatic model_step();
    logic [4:0] set;
    logic n_en, n_gce, n_sta, n_ack, n_sto, n_ie, n_arm, n_rel, n_gc;
    logic [4:0] n_flg;
    set = {ev_stop_sent, ev_addr_match, ev_byte_done, ev_hdr10, ev_start_sent};
    if (rst) begin
      {n_en, n_gce, n_sta, n_ack, n_sto, n_ie, n_arm, n_rel, n_gc} = '0;
      n_flg = '0;
    end else begin
      {n_en, n_gce, n_sta, n_ack, n_sto, n_ie} = {m_en, m_gce, m_sta, m_ack, m_sto, m_ie};
      if (wr_en) begin
        n_en = wr_data[5];
        if (m_en) begin
          n_gce = wr_data[5] && wr_data[4];
          n_sta = wr_data[5] && wr_data[3];
          n_ack = wr_data[5] && wr_data[2];
          n_sto = wr_data[1];
          n_ie  = wr_data[5] && wr_data[0];
        end
      end else begin
        if (m_en && ev_start_sent) n_sta = 0;
        if (m_en && is_master && ev_stop_sent) n_sto = 0;
      end
      n_flg[4] = (m_flg[4] && !flag_clr[4]) || set[4];
      n_flg[3:0] = m_en ? ((m_flg[3:0] & ~flag_clr[3:0]) | set[3:0]) : 4'b0;
      if (!m_en || ev_stop_sent) n_arm = 0;
      else n_arm = m_arm || ev_start_sent || ev_byte_done;
      if (!m_en || !m_sto || is_master) n_rel = 0;
      else n_rel = m_rel || ev_byte_done;
      n_gc = m_en && m_gce && addr_valid && addr_byte == 8'h00;
    end
    {m_en, m_gce, m_sta, m_ack, m_sto, m_ie, m_arm, m_rel, m_gc} =
      {n_en, n_gce, n_sta, n_ack, n_sto, n_ie, n_arm, n_rel, n_gc};
    m_flg = n_flg;
  endtask

  task automatic compare_all();
    chk("R2 rd_data", rd_data, m_reg());
    chk("R6 req_start", req_start, m_en && m_sta && (is_master || bus_free));
    chk("R8 req_stop", req_stop, m_en && is_master && m_sto && !m_sta && m_arm);
    chk("R7 ack_out", ack_out, m_en && m_ack);
    chk("R4 gc_ack", gc_ack, m_gc);
    chk("R9 release_lines", release_lines, m_en && m_rel);
    chk("R10 scl_hold", scl_hold, m_en && ((|m_flg[3:0]) || hold_pend));
    chk("R11 irq", irq, m_ie && (|m_flg));
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    compare_all();
    wr_en = 0; ev_start_sent = 0; ev_stop_sent = 0; ev_byte_done = 0;
    ev_addr_match = 0; ev_hdr10 = 0; addr_valid = 0; flag_clr = 0;
  endtask

  task automatic wr(logic [7:0] d);
    wr_en = 1; wr_data = d; tick();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int unsigned r;
    r = $urandom(32'h5eed_0721);
    rst = 1; tick(); tick(); rst = 0;
    chk("R1 reset value", rd_data, 8'h00);
    chk("R1 reset irq", irq, 0);

    // R2: two-write enable
    wr(8'hFF);
    chk("R2 first write sets only enable", rd_data, 8'h20);
    is_master = 1;
    wr(8'hFF);
    chk("R2 second write loads bits", rd_data, 8'h3F);
    chk("R1 reserved bits read zero", rd_data[7:6], 2'b00);
    chk("R7 ack follows bit", ack_out, 1);

    // R8: start first, then stop
    chk("R8 start before stop: start", req_start, 1);
    chk("R8 start before stop: stop", req_stop, 0);
    ev_start_sent = 1; tick();
    chk("R5 start bit cleared", rd_data[3], 0);
    chk("R5 start-sent irq", irq, 1);
    chk("R8 stop after start: start", req_start, 0);
    chk("R8 stop after start: stop", req_stop, 1);
    chk("R10 hold on start flag", scl_hold, 1);
    ev_stop_sent = 1; tick();
    chk("R8 stop bit cleared by hw", rd_data, 8'h35);
    chk("R8 stop request gone", req_stop, 0);

    // R4: general call
    addr_valid = 1; addr_byte = 8'h00; tick();
    chk("R4 gc 00h", gc_ack, 1);
    addr_valid = 1; addr_byte = 8'h01; tick();
    chk("R4 gc 01h", gc_ack, 0);

    // R11: clear flags
    flag_clr = 5'b11111; tick();
    chk("R11 irq after clear", irq, 0);
    chk("R10 hold after clear", scl_hold, 0);
    hold_pend = 1; tick();
    chk("R10 hold on pending read", scl_hold, 1);
    hold_pend = 0;

    // R6: slave start waits for free bus
    is_master = 0; bus_free = 0;
    wr(8'h28);
    chk("R6 slave start, bus busy", req_start, 0);
    bus_free = 1; tick();
    chk("R6 slave start, bus free", req_start, 1);
    ev_start_sent = 1; tick();
    chk("R5 slave start cleared", rd_data[3], 0);
    bus_free = 0;

    // R9: slave stop
    wr(8'h22);
    chk("R9 no release before byte", release_lines, 0);
    ev_byte_done = 1; tick();
    chk("R9 release after byte", release_lines, 1);
    ev_stop_sent = 1; tick();
    chk("R9 stop kept in slave", rd_data[1], 1);

    // R3: disable keeps stop, releases outputs
    ev_byte_done = 1; wr(8'h02);
    chk("R3 disabled reads", rd_data, 8'h02);
    chk("R3 release dropped", release_lines, 0);
    chk("R3 hold dropped", scl_hold, 0);
    tick();
    chk("R3 flags cleared", scl_hold, 0);
    wr(8'hFF);
    chk("R2 disabled write keeps stop", rd_data, 8'h22);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 32) == 0) is_master = ~is_master;
      if (($urandom % 8) == 0)  bus_free = ~bus_free;
      if (($urandom % 16) == 0) hold_pend = ~hold_pend;
      wr_en = ($urandom % 8) == 0;
      wr_data = 8'($urandom);
      if (($urandom % 4) != 0) wr_data[5] = 1'b1;
      ev_start_sent = ($urandom % 10) == 0;
      ev_stop_sent  = ($urandom % 12) == 0;
      ev_byte_done  = ($urandom % 8) == 0;
      ev_addr_match = ($urandom % 14) == 0;
      ev_hdr10      = ($urandom % 20) == 0;
      addr_valid    = ($urandom % 6) == 0;
      case ($urandom % 3)
        0: addr_byte = 8'h00;
        1: addr_byte = 8'h01;
        default: addr_byte = 8'($urandom);
      endcase
      if (($urandom % 5) == 0) flag_clr = 5'($urandom);
      tick();
    end
    finish_run();
  end
endmodule